// File: doc/BRIEF.md
# Packet Buffer Port Controller

This block drives one port of a synchronous dual-port line buffer and connects it to two streaming packet interfaces. A 32-bit command word, qualified by a single-cycle `go` strobe, chooses one of three operations: return to idle, stream a range of buffer lines out to a consumer, or fill a range of buffer lines from a producer. A range is given by its first and last line. When the last line is numerically below the first, the range runs past the top line and continues from line 0.

In read mode the controller fetches lines ahead of the consumer, so that a line is ready at once whenever the consumer asks for one. The first line of the range is flagged as packet start and the last as packet end. In write mode every accepted word goes to the next line of the range. A word marked as packet end closes the transfer early. The block reports completion on `done` and a failed transfer on `error`, and both stay set until the next command.

The RAM port is expected to return read data one clock after the enable and address are presented, and to hold its output while the enable is low.

Top module: `pkt_buf_port`

## Requirements
- R1: The command word holds firstline in bits [AW-1:0], lastline in [2AW-1:AW], step in [2AW+3:2AW], a read bit at 2AW+4, a write bit at 2AW+5 and a clear bit at 2AW+6. With AW=9 these are bits 8:0, 17:9, 21:18, 22, 23 and 24. The word is latched in the cycle `go` is high. If more than one mode bit is set, clear wins over write and write wins over read.
- R2: After reset, and one cycle after a clear command, `done`, `error`, `rdReady` and `wrReady` are all low.
- R3: A read command delivers the lines firstline, firstline+1, ... in address order, modulo 2^AW, through lastline. That is ((lastline − firstline) mod 2^AW) + 1 lines, and a range with lastline below firstline wraps from line 2^AW−1 to line 0.
- R4: `rdFlags` bit 0 marks the first line of a read range and bit 1 marks its last line. Bits 3:2 are always 0, and the whole bus is 0 while `rdReady` is low.
- R5: While `rdReady` is high and `rdRead` is low, `rdData` and `rdReady` hold. Once the first line is offered, a consumer that keeps `rdRead` high receives one line per clock with no stall.
- R6: Consuming the line flagged as packet end raises `done` on the next cycle and drops `rdReady`.
- R7: A read handshake with `rdError` high ends the read transfer, raises `error`, leaves `done` low and drops `rdReady`.
- R8: `wrReady` is high throughout write mode. Each accepted word with `wrFlags[1:0]` not 2'b11 drives `ramEn` and `ramWe` in the same cycle, with `ramAddr` set to the next line of the range and `ramWrData` equal to `wrData`.
- R9: An accepted write word with `wrFlags` bit 1 (end) set is stored, then ends the transfer with `done` high, even if the range is not full.
- R10: An accepted write word with `wrFlags[1:0]` = 2'b11 is not stored, ends the transfer and raises `error`.
- R11: Storing the last line of the range without an end flag raises `done` and drops `wrReady`. Write strobes that follow cause no RAM write until a new command arrives.
- R12: A new command issued in the middle of a read or write transfer discards the old transfer, clears `done` and `error`, and starts the new one from its first line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrlWord | input | 32 | Command word: range, step and mode bits |
| go | input | 1 | One-cycle command strobe |
| done | output | 1 | Transfer completed |
| error | output | 1 | Transfer ended with an error |
| ramEn | output | 1 | RAM port enable |
| ramWe | output | 1 | RAM port write enable |
| ramAddr | output | AW | RAM line address |
| ramWrData | output | DW | Data written to the RAM |
| ramRdData | input | DW | Data read from the RAM, one cycle after the enable |
| wrData | input | DW | Producer data word |
| wrFlags | input | 4 | Producer flags: bit 0 start, bit 1 end |
| wrWrite | input | 1 | Producer write strobe |
| wrReady | output | 1 | Block accepts producer words |
| rdData | output | DW | Consumer data word |
| rdFlags | output | 4 | Consumer flags: bit 0 start, bit 1 end, bits 3:2 zero |
| rdReady | output | 1 | A line is offered to the consumer |
| rdRead | input | 1 | Consumer read strobe |
| rdError | input | 1 | Consumer error, qualified by rdRead |

## Verification
The bench builds the block with AW=5 and DW=32, so the buffer has 32 lines. With that size, a transfer over the whole buffer and ranges that cross from line 31 back to line 0 each take only a few dozen cycles. That allows full-buffer reads, wrapped writes, and reads of wrapped writes to all run next to the abort, error, early-end and priority cases. The behavioural model keeps its own copy of the line contents and its own list of expected read lines, and it compares the handshakes, the RAM strobes and the status outputs on every clock.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // latch range and step from the command
    logic adv;    // one line issued (read) or stored (write)
    logic move;   // RAM output captured into the consumer register
  } strobe_t;

endpackage

// File: rtl/pbp_datapath.sv
module pbp_datapath
  import pbp_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       strb,
  input  logic [AW-1:0] cfgFirst,
  input  logic [AW-1:0] cfgLast,
  input  logic [3:0]    cfgStep,
  input  logic [DW-1:0] ramRdData,
  output logic [AW-1:0] curAddr,
  output logic          remZero,
  output logic          remLast,
  output logic [DW-1:0] outData,
  output logic          outSop,
  output logic          outEop
);

  localparam int CW = AW + 1;

  logic [CW-1:0] remCnt;
  logic [3:0]    stepReg;
  logic          firstPend;
  logic          pendSop;
  logic          pendEop;
  logic [AW-1:0] span;

  assign span    = cfgLast - cfgFirst;
  assign remZero = (remCnt == '0);
  assign remLast = (remCnt == CW'(1));

  // range sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr   <= '0;
      remCnt    <= '0;
      stepReg   <= 4'd1;
      firstPend <= 1'b0;
      pendSop   <= 1'b0;
      pendEop   <= 1'b0;
    end else if (strb.load) begin
      curAddr   <= cfgFirst;
      remCnt    <= CW'(span) + CW'(1);
      stepReg   <= cfgStep;
      firstPend <= 1'b1;
    end else if (strb.adv) begin
      curAddr   <= curAddr + AW'(stepReg);
      remCnt    <= remCnt - CW'(1);
      pendSop   <= firstPend;
      pendEop   <= remLast;
      firstPend <= 1'b0;
    end
  end

  // consumer-side holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= '0;
      outSop  <= 1'b0;
      outEop  <= 1'b0;
    end else if (strb.move) begin
      outData <= ramRdData;
      outSop  <= pendSop;
      outEop  <= pendEop;
    end
  end

endmodule

// File: rtl/pbp_ctrl.sv
module pbp_ctrl
  import pbp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    go,
  input  logic    cmdClear,
  input  logic    cmdWrite,
  input  logic    cmdRead,
  input  logic    remZero,
  input  logic    remLast,
  input  logic    outEop,
  input  logic    rdRead,
  input  logic    rdError,
  input  logic    wrWrite,
  input  logic    wrSop,
  input  logic    wrEop,
  output strobe_t strb,
  output logic    ramEn,
  output logic    ramWe,
  output logic    rdReady,
  output logic    wrReady,
  output logic    done,
  output logic    error
);

  mode_e mode, modeNext;
  logic  pending;   // a fetched line sits on the RAM output
  logic  outValid;  // a line sits in the consumer register

  logic consume, rdAbort, rdFinish, room, issue, move;
  logic accept, badWord, store, wrFinish, load;

  always_comb begin
    consume  = (mode == MODE_READ) && outValid && rdRead && !go;
    rdAbort  = consume && rdError;
    rdFinish = consume && !rdError && outEop;
    room     = !pending || !outValid || consume;
    issue    = (mode == MODE_READ) && !go && !remZero && !rdAbort && room;
    move     = (mode == MODE_READ) && !go && pending && !rdAbort &&
               (!outValid || consume);
    accept   = (mode == MODE_WRITE) && wrWrite && !go;
    badWord  = accept && wrSop && wrEop;
    store    = accept && !badWord;
    wrFinish = store && (wrEop || remLast);
    load     = go && !cmdClear && (cmdWrite || cmdRead);
  end

  always_comb begin
    modeNext = mode;
    if (go) begin
      if (cmdClear)      modeNext = MODE_IDLE;
      else if (cmdWrite) modeNext = MODE_WRITE;
      else if (cmdRead)  modeNext = MODE_READ;
      else               modeNext = MODE_IDLE;
    end else if (rdAbort || rdFinish || badWord || wrFinish) begin
      modeNext = MODE_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_IDLE;
      pending  <= 1'b0;
      outValid <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      mode <= modeNext;
      if (go) begin
        pending  <= 1'b0;
        outValid <= 1'b0;
        done     <= 1'b0;
        error    <= 1'b0;
      end else begin
        if (rdAbort)      pending <= 1'b0;
        else if (issue)   pending <= 1'b1;
        else if (move)    pending <= 1'b0;

        if (rdAbort || rdFinish) outValid <= 1'b0;
        else if (move)           outValid <= 1'b1;
        else if (consume)        outValid <= 1'b0;

        if (rdFinish || wrFinish) done  <= 1'b1;
        if (rdAbort || badWord)   error <= 1'b1;
      end
    end
  end

  assign strb.load = load;
  assign strb.adv  = issue || store;
  assign strb.move = move;
  assign ramEn     = issue || store;
  assign ramWe     = store;
  assign rdReady   = outValid;
  assign wrReady   = (mode == MODE_WRITE);

endmodule

// File: rtl/pkt_buf_port.sv
module pkt_buf_port
  import pbp_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   ctrlWord,
  input  logic          go,
  output logic          done,
  output logic          error,
  output logic          ramEn,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramWrData,
  input  logic [DW-1:0] ramRdData,
  input  logic [DW-1:0] wrData,
  input  logic [3:0]    wrFlags,
  input  logic          wrWrite,
  output logic          wrReady,
  output logic [DW-1:0] rdData,
  output logic [3:0]    rdFlags,
  output logic          rdReady,
  input  logic          rdRead,
  input  logic          rdError
);

  localparam int LAST_LSB = AW;
  localparam int STEP_LSB = 2 * AW;
  localparam int RD_BIT   = 2 * AW + 4;
  localparam int WR_BIT   = 2 * AW + 5;
  localparam int CLR_BIT  = 2 * AW + 6;

  strobe_t strb;
  logic    remZero, remLast, outSop, outEop;
  logic    unusedBits;

  assign unusedBits = ^{ctrlWord[31:CLR_BIT+1], wrFlags[3:2]};

  pbp_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .cmdClear (ctrlWord[CLR_BIT]),
    .cmdWrite (ctrlWord[WR_BIT]),
    .cmdRead  (ctrlWord[RD_BIT]),
    .remZero  (remZero),
    .remLast  (remLast),
    .outEop   (outEop),
    .rdRead   (rdRead),
    .rdError  (rdError),
    .wrWrite  (wrWrite),
    .wrSop    (wrFlags[0]),
    .wrEop    (wrFlags[1]),
    .strb     (strb),
    .ramEn    (ramEn),
    .ramWe    (ramWe),
    .rdReady  (rdReady),
    .wrReady  (wrReady),
    .done     (done),
    .error    (error)
  );

  pbp_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .cfgFirst  (ctrlWord[AW-1:0]),
    .cfgLast   (ctrlWord[LAST_LSB +: AW]),
    .cfgStep   (ctrlWord[STEP_LSB +: 4]),
    .ramRdData (ramRdData),
    .curAddr   (ramAddr),
    .remZero   (remZero),
    .remLast   (remLast),
    .outData   (rdData),
    .outSop    (outSop),
    .outEop    (outEop)
  );

  assign ramWrData = wrData;
  assign rdFlags   = rdReady ? {2'b00, outEop, outSop} : 4'b0000;

endmodule

// File: rtl/pkt_buf_port_chk.sv
module pkt_buf_port_chk #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [31:0]   ctrlWord,
  input logic          go,
  input logic          done,
  input logic          error,
  input logic          ramEn,
  input logic          ramWe,
  input logic [DW-1:0] rdData,
  input logic [3:0]    rdFlags,
  input logic          rdReady,
  input logic          rdRead,
  input logic          rdError,
  input logic [3:0]    wrFlags,
  input logic          wrWrite,
  input logic          wrReady
);

  localparam int CLR_BIT = 2 * AW + 6;

  // R2
  clear_idles_chk: assert property (@(posedge clk) disable iff (rst)
    go && ctrlWord[CLR_BIT] |=> !done && !error && !rdReady && !wrReady);

  // R4
  rd_flags_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (rdFlags[3:2] == 2'b00) && (rdReady || rdFlags == 4'b0000));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rdReady && !rdRead && !go |=> rdReady && $stable(rdData) && $stable(rdFlags));

  // R6
  rd_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !rdReady && !wrReady && !error);

  // R7
  rd_error_chk: assert property (@(posedge clk) disable iff (rst)
    rdRead && rdReady && rdError && !go |=> error && !done && !rdReady);

  // R8
  wr_store_chk: assert property (@(posedge clk) disable iff (rst)
    wrWrite && wrReady && !go && (wrFlags[1:0] != 2'b11) |-> ramEn && ramWe);

  // R10
  wr_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> wrWrite && wrReady && (wrFlags[1:0] != 2'b11));

  // R12
  new_cmd_clears_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> !done && !error && !rdReady);

endmodule

bind pkt_buf_port pkt_buf_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctrlWord (ctrlWord),
  .go       (go),
  .done     (done),
  .error    (error),
  .ramEn    (ramEn),
  .ramWe    (ramWe),
  .rdData   (rdData),
  .rdFlags  (rdFlags),
  .rdReady  (rdReady),
  .rdRead   (rdRead),
  .rdError  (rdError),
  .wrFlags  (wrFlags),
  .wrWrite  (wrWrite),
  .wrReady  (wrReady)
);

// File: tb/pkt_buf_port_tb.sv
module pkt_buf_port_tb;

  localparam int AW = 5;
  localparam int DW = 32;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   ctrlWord = '0;
  logic          go = 1'b0;
  logic          done, error, ramEn, ramWe, wrReady, rdReady;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWrData, rdData;
  logic [DW-1:0] ramRdData;
  logic [DW-1:0] wrData = '0;
  logic [3:0]    wrFlags = '0;
  logic          wrWrite = 1'b0;
  logic [3:0]    rdFlags;
  logic          rdRead = 1'b0;
  logic          rdError = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pkt_buf_port #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .ctrlWord(ctrlWord), .go(go),
    .done(done), .error(error),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWrData(ramWrData), .ramRdData(ramRdData),
    .wrData(wrData), .wrFlags(wrFlags), .wrWrite(wrWrite), .wrReady(wrReady),
    .rdData(rdData), .rdFlags(rdFlags), .rdReady(rdReady),
    .rdRead(rdRead), .rdError(rdError)
  );

  // bench RAM: one-cycle read latency, output held while disabled
  logic [DW-1:0] mem [N];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= 32'hC0DE_0000 + 32'(i);
      ramRdData <= '0;
    end else if (ramEn) begin
      if (ramWe) mem[ramAddr] <= ramWrData;
      ramRdData <= mem[ramAddr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    logic [DW-1:0] d;
    bit            s;
    bit            e;
  } exp_t;

  exp_t          expQ[$];
  logic [DW-1:0] refMem [N];
  int            mMode;   // 0 idle, 1 read, 2 write
  int            mAddr, mRem;
  bit            mDone, mErr;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) refMem[i] = 32'hC0DE_0000 + 32'(i);
      mMode = 0; mAddr = 0; mRem = 0; mDone = 0; mErr = 0;
      expQ.delete();
    end else begin
      chk(done == mDone, "R6", "done", done, mDone);
      chk(error == mErr, "R7", "error", error, mErr);
      chk(wrReady == (mMode == 2), "R8", "wrReady", wrReady, mMode == 2);
      chk(!rdReady || mMode == 1, "R3", "rdReady outside read", rdReady, 0);
      chk(rdFlags[3:2] == 2'b00 && (rdReady || rdFlags == 4'b0), "R4",
          "rdFlags shape", rdFlags, {2'b00, rdFlags[1:0] & {2{rdReady}}});
      if (mMode != 2) chk(ramWe == 1'b0, "R11", "ramWe outside write", ramWe, 0);

      if (go) begin
        int f, l, cnt;
        f = int'(ctrlWord[AW-1:0]);
        l = int'(ctrlWord[2*AW-1:AW]);
        mDone = 0; mErr = 0;
        expQ.delete();
        if (ctrlWord[2*AW+6])      mMode = 0;
        else if (ctrlWord[2*AW+5]) mMode = 2;
        else if (ctrlWord[2*AW+4]) mMode = 1;
        else                       mMode = 0;
        cnt = ((l - f + N) % N) + 1;
        mAddr = f; mRem = cnt;
        if (mMode == 1)
          for (int k = 0; k < cnt; k++) begin
            exp_t e;
            e.d = refMem[(f + k) % N];
            e.s = (k == 0);
            e.e = (k == cnt - 1);
            expQ.push_back(e);
          end
      end else if (mMode == 1 && rdRead && rdReady) begin
        exp_t e;
        chk(expQ.size() > 0, "R3", "unexpected extra line", expQ.size(), 1);
        if (expQ.size() > 0) begin
          e = expQ.pop_front();
          chk(rdData == e.d, "R3", "rdData", rdData, e.d);
          chk(rdFlags[0] == e.s, "R4", "start flag", rdFlags[0], e.s);
          chk(rdFlags[1] == e.e, "R4", "end flag", rdFlags[1], e.e);
          if (rdError) begin
            mErr = 1; mMode = 0; expQ.delete();
          end else if (e.e) begin
            mDone = 1; mMode = 0;
          end
        end
      end else if (mMode == 2 && wrWrite) begin
        if (wrFlags[1:0] == 2'b11) begin
          chk(ramWe == 1'b0, "R10", "bad word stored", ramWe, 0);
          mErr = 1; mMode = 0;
        end else begin
          chk(ramEn && ramWe, "R8", "ram strobes", {ramEn, ramWe}, 2'b11);
          chk(int'(ramAddr) == mAddr, "R8", "ramAddr", ramAddr, mAddr);
          chk(ramWrData == wrData, "R8", "ramWrData", ramWrData, wrData);
          refMem[mAddr] = wrData;
          mAddr = (mAddr + 1) % N;
          mRem--;
          if (wrFlags[1] || mRem == 0) begin
            mDone = 1; mMode = 0;
          end
        end
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic cmd(input bit c, input bit w, input bit r, input int f, input int l);
    @(posedge clk); #1;
    ctrlWord = '0;
    ctrlWord[AW-1:0]         = AW'(f);
    ctrlWord[2*AW-1:AW]      = AW'(l);
    ctrlWord[2*AW+3:2*AW]    = 4'd1;
    ctrlWord[2*AW+4]         = r;
    ctrlWord[2*AW+5]         = w;
    ctrlWord[2*AW+6]         = c;
    go = 1'b1;
    @(posedge clk); #1;
    go = 1'b0;
  endtask

  // returns the number of cycles the consumer waited after the first line
  task automatic readLines(input int n, input int waits, input bit errLast,
                           output int stalls);
    stalls = 0;
    for (int i = 0; i < n; i++) begin
      while (!rdReady) begin
        @(posedge clk); #1;
        if (i > 0) stalls++;
      end
      rdError = errLast && (i == n - 1);
      rdRead  = 1'b1;
      @(posedge clk); #1;
      rdRead  = 1'b0;
      rdError = 1'b0;
      repeat (waits) begin @(posedge clk); #1; end
    end
  endtask

  task automatic writeOne(input logic [DW-1:0] d, input bit sop, input bit eop);
    while (!wrReady) begin @(posedge clk); #1; end
    wrData  = d;
    wrFlags = {2'b00, eop, sop};
    wrWrite = 1'b1;
    @(posedge clk); #1;
    wrWrite = 1'b0;
    wrFlags = '0;
  endtask

  task automatic idleCycles(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    int st;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!done && !error && !rdReady && !wrReady, "R2", "reset state",
        {done, error, rdReady, wrReady}, 0);

    // R3 R5 R6: full read, no wait states
    cmd(0, 0, 1, 5, 10);
    readLines(6, 0, 0, st);
    chk(st == 0, "R5", "stalls on back-to-back reads", st, 0);
    @(negedge clk);
    chk(done && !rdReady, "R6", "done after end line", {done, rdReady}, 2'b10);
    chk(expQ.size() == 0, "R3", "lines left", expQ.size(), 0);

    // R5: wait states between reads
    cmd(0, 0, 1, 5, 10);
    readLines(6, 2, 0, st);
    @(negedge clk);
    chk(done, "R5", "done after waited read", done, 1);

    // R12: partial read then restart
    cmd(0, 0, 1, 5, 10);
    readLines(3, 0, 0, st);
    idleCycles(4);
    cmd(0, 0, 1, 5, 10);
    @(negedge clk);
    chk(!done && !error, "R12", "status cleared by new command", {done, error}, 0);
    readLines(6, 0, 0, st);
    @(negedge clk);
    chk(done && expQ.size() == 0, "R12", "restarted read complete", done, 1);

    // R7: error on third line
    cmd(0, 0, 1, 5, 10);
    readLines(3, 3, 1, st);
    @(negedge clk);
    chk(error && !done && !rdReady, "R7", "error abort",
        {error, done, rdReady}, 3'b100);

    // R3: wrapped range and whole buffer
    cmd(0, 0, 1, 27, 3);
    readLines(9, 0, 0, st);
    @(negedge clk);
    chk(done && expQ.size() == 0, "R3", "wrapped read count", expQ.size(), 0);
    cmd(0, 0, 1, 0, N - 1);
    readLines(N, 0, 0, st);
    chk(st == 0, "R5", "stalls on whole-buffer read", st, 0);

    // R8 R11: full write, then ignored strobe
    cmd(0, 1, 0, 10, 15);
    for (int i = 0; i < 6; i++) writeOne(32'h1000 + 32'(i), i == 0, 0);
    @(negedge clk);
    chk(done && !wrReady, "R11", "done when range filled", {done, wrReady}, 2'b10);
    #1 wrWrite = 1'b1; wrData = 32'hDEAD;
    @(posedge clk); #1 wrWrite = 1'b0;
    @(negedge clk);
    chk(!ramWe && done, "R11", "late strobe ignored", ramWe, 0);

    // R9: early end on the fourth word
    cmd(0, 1, 0, 18, 25);
    for (int i = 0; i < 4; i++) writeOne(32'h2000 + 32'(i), i == 0, i == 3);
    @(negedge clk);
    chk(done && !wrReady, "R9", "early end completes", {done, wrReady}, 2'b10);

    // R10: start and end together
    cmd(0, 1, 0, 26, 30);
    writeOne(32'h3000, 1, 0);
    writeOne(32'h3001, 1, 1);
    @(negedge clk);
    chk(error && !done && !wrReady, "R10", "both flags error",
        {error, done, wrReady}, 3'b100);

    // wrapped write, then read the whole buffer back
    cmd(0, 1, 0, 29, 2);
    for (int i = 0; i < 6; i++) writeOne(32'h4000 + 32'(i), 0, 0);
    @(negedge clk);
    chk(done, "R8", "wrapped write done", done, 1);
    cmd(0, 0, 1, 0, N - 1);
    readLines(N, 1, 0, st);
    @(negedge clk);
    chk(done && expQ.size() == 0, "R8", "readback complete", expQ.size(), 0);

    // R1: write wins over read; clear wins over write
    cmd(0, 1, 1, 3, 4);
    @(negedge clk);
    chk(wrReady && !rdReady, "R1", "write over read", {wrReady, rdReady}, 2'b10);
    writeOne(32'h5000, 0, 0);
    cmd(1, 1, 0, 3, 4);
    @(negedge clk);
    chk(!wrReady && !rdReady && !done && !error, "R1", "clear over write",
        {wrReady, rdReady, done, error}, 0);

    // R2 R12: clear during an active write
    cmd(0, 1, 0, 0, N - 1);
    writeOne(32'h6000, 1, 0);
    writeOne(32'h6001, 0, 0);
    cmd(1, 0, 0, 0, 0);
    @(negedge clk);
    chk(!wrReady && !done && !error, "R2", "clear aborts write",
        {wrReady, done, error}, 0);
    cmd(0, 0, 1, 0, 2);
    readLines(3, 0, 0, st);
    @(negedge clk);
    chk(done, "R12", "read after aborted write", done, 1);

    idleCycles(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule